// File: doc/BRIEF.md
# Synchronous Software Reset Controller

This block turns a software reset request into an operation-level reset pulse. It also turns a watchdog request into a settings-level reset pulse, and it records the cause of each reset. Software reaches three registers through a simple register port: a standby control register, a timebase control register and a reset source register. A software request stays pending while the bus is busy or synchronous reset mode is off. It is released only at a clock edge where the bus-idle input is high and the mode bit is set, so the delay before the reset depends on bus traffic.

Register addresses are 0 for standby control, 1 for timebase control and 2 for reset source. Each reset pulse lasts `PULSE_LEN` cycles (default 4). A settings-level reset from the watchdog also raises a flag that tells downstream clock logic to skip the oscillation stabilization wait. At most one of the two reset pulses is active at any time.

Top module: `swrst_ctrl`

## Requirements
- R1: While `rstN` is low, every register, cause flag and pending request is cleared. After release, `opRst`, `setRst` and `skipOscWait` are 0, address 0 reads 0x0010, and addresses 1 and 2 read 0x0000.
- R2: A write to address 0 with bit 4 equal to 0 makes a software request pending, and address 0 then reads bit 4 as 0. A write with bit 4 equal to 1 does not create a request.
- R3: A pending request produces no `opRst` while `busIdle` is 0 or bit 7 of address 1 (synchronous mode) is 0. It stays pending with no time limit.
- R4: At a clock edge where the request is pending, `busIdle` is 1, synchronous mode is 1 and no pulse is active, `opRst` rises after that edge. It stays high for exactly `PULSE_LEN` cycles, and the pending request is cleared at the same edge, so address 0 bit 4 reads 1 again.
- R5: An operation-level reset sets bit 11 of address 2, visible from the first pulse cycle. It never raises `setRst`.
- R6: A one-cycle `wdogReq` sampled at an edge with no pulse active and no operation-level reset starting raises `setRst` and `skipOscWait` after that edge for `PULSE_LEN` cycles, and sets bit 13 of address 2.
- R7: A settings-level reset discards any pending software request, so no operation-level reset follows it.
- R8: A `wdogReq` sampled at the edge where an operation-level reset starts, or at any edge while a pulse is active, is discarded. The operation-level reset wins.
- R9: Reading address 2 returns the cause flags and clears them at that edge. A flag set at the same edge as the read survives the clear.
- R10: Writes to address 2 have no effect. Only bits 11 and 13 of address 2 can ever read as 1.
- R11: `opRst` and `setRst` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low power-on reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address |
| wrData | input | 16 | Write data |
| rdEn | input | 1 | Register read strobe (side effect on address 2) |
| rdAddr | input | 2 | Read address |
| rdData | output | 16 | Read data, combinational from `rdAddr` |
| busIdle | input | 1 | High when all bus traffic has stopped |
| wdogReq | input | 1 | One-cycle settings-level reset request from the watchdog |
| opRst | output | 1 | Operation-level reset pulse |
| setRst | output | 1 | Settings-level reset pulse |
| skipOscWait | output | 1 | High during a watchdog reset: skip oscillation stabilization wait |

## Verification
The release of a pending software request and the arrival of a watchdog request can fall on the same clock edge, or the watchdog request can land inside the operation pulse. The bench keeps a request pending with the bus busy and then raises `busIdle`. It sweeps the watchdog strobe over every offset from one edge before the release to two edges after the pulse ends. For each offset it counts the high cycles of each pulse, records when `opRst` rises, and reads the cause flags. A second collision puts a cause-flag read-clear on the same edge as a new watchdog flag; the bench expects the new flag to survive.

// File: rtl/swrst_pkg.sv
package swrst_pkg;
  localparam int REG_ADDR_W = 2;
  localparam int REG_DATA_W = 16;

  localparam logic [REG_ADDR_W-1:0] ADDR_STBY  = 2'd0;
  localparam logic [REG_ADDR_W-1:0] ADDR_TBASE = 2'd1;
  localparam logic [REG_ADDR_W-1:0] ADDR_SRC   = 2'd2;

  localparam int STBY_REQ_BIT = 4;
  localparam int TB_SYNC_BIT  = 7;
  localparam int SRC_SW_BIT   = 11;
  localparam int SRC_WD_BIT   = 13;

  typedef struct packed {
    logic startOp;
    logic startSet;
  } ctlStrobe_t;
endpackage

// File: rtl/swrst_regs.sv
module swrst_regs
  import swrst_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [REG_ADDR_W-1:0] wrAddr,
  input  logic [REG_DATA_W-1:0] wrData,
  input  logic                  rdEn,
  input  logic [REG_ADDR_W-1:0] rdAddr,
  input  ctlStrobe_t            strobe,
  output logic [REG_DATA_W-1:0] rdData,
  output logic                  swPend,
  output logic                  syncMode
);
  localparam logic [REG_DATA_W-1:0] REQ_MASK = REG_DATA_W'(1) << STBY_REQ_BIT;

  logic [REG_DATA_W-1:0] stbyReg;
  logic [REG_DATA_W-1:0] tbReg;
  logic                  swCause;
  logic                  wdCause;
  logic                  stbyWr;
  logic                  tbWr;
  logic                  srcClr;
  logic                  reqWrite;

  assign stbyWr   = wrEn && (wrAddr == ADDR_STBY);
  assign tbWr     = wrEn && (wrAddr == ADDR_TBASE);
  assign srcClr   = rdEn && (rdAddr == ADDR_SRC);
  assign reqWrite = stbyWr && !wrData[STBY_REQ_BIT];
  assign syncMode = tbReg[TB_SYNC_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stbyReg <= REQ_MASK;
      tbReg   <= '0;
    end else begin
      if (stbyWr) stbyReg <= wrData | REQ_MASK;
      if (tbWr)   tbReg   <= wrData;
    end
  end

  // a new request written at the release edge is kept as a fresh request
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                   swPend <= 1'b0;
    else if (reqWrite)                           swPend <= 1'b1;
    else if (strobe.startOp || strobe.startSet)  swPend <= 1'b0;
  end

  // setting a cause takes precedence over the read-clear at the same edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      swCause <= 1'b0;
      wdCause <= 1'b0;
    end else begin
      if (strobe.startOp)  swCause <= 1'b1;
      else if (srcClr)     swCause <= 1'b0;
      if (strobe.startSet) wdCause <= 1'b1;
      else if (srcClr)     wdCause <= 1'b0;
    end
  end

  always_comb begin
    rdData = '0;
    unique case (rdAddr)
      ADDR_STBY:  rdData = stbyReg & ~(swPend ? REQ_MASK : '0);
      ADDR_TBASE: rdData = tbReg;
      ADDR_SRC: begin
        rdData[SRC_SW_BIT] = swCause;
        rdData[SRC_WD_BIT] = wdCause;
      end
      default:    rdData = '0;
    endcase
  end
endmodule

// File: rtl/swrst_seq.sv
module swrst_seq
  import swrst_pkg::*;
#(
  parameter int PULSE_LEN = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       swPend,
  input  logic       syncMode,
  input  logic       busIdle,
  input  logic       wdogReq,
  output ctlStrobe_t strobe,
  output logic       opRst,
  output logic       setRst,
  output logic       skipOscWait
);
  localparam int CNT_W = $clog2(PULSE_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_LEN);

  logic [CNT_W-1:0] opCnt;
  logic [CNT_W-1:0] setCnt;
  logic             quiet;

  assign quiet = (opCnt == '0) && (setCnt == '0);

  always_comb begin
    strobe.startOp  = quiet && swPend && busIdle && syncMode;
    strobe.startSet = quiet && wdogReq && !strobe.startOp;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opCnt  <= '0;
      setCnt <= '0;
    end else begin
      if (strobe.startOp)      opCnt <= CNT_LOAD;
      else if (opCnt != '0)    opCnt <= opCnt - CNT_W'(1);
      if (strobe.startSet)     setCnt <= CNT_LOAD;
      else if (setCnt != '0)   setCnt <= setCnt - CNT_W'(1);
    end
  end

  assign opRst       = (opCnt != '0);
  assign setRst      = (setCnt != '0);
  assign skipOscWait = setRst;
endmodule

// File: rtl/swrst_ctrl.sv
module swrst_ctrl
  import swrst_pkg::*;
#(
  parameter int PULSE_LEN = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [1:0]  wrAddr,
  input  logic [15:0] wrData,
  input  logic        rdEn,
  input  logic [1:0]  rdAddr,
  output logic [15:0] rdData,
  input  logic        busIdle,
  input  logic        wdogReq,
  output logic        opRst,
  output logic        setRst,
  output logic        skipOscWait
);
  ctlStrobe_t strobe;
  logic       swPend;
  logic       syncMode;

  swrst_regs regs_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .strobe(strobe), .rdData(rdData),
    .swPend(swPend), .syncMode(syncMode)
  );

  swrst_seq #(.PULSE_LEN(PULSE_LEN)) seq_i (
    .clk(clk), .rstN(rstN), .swPend(swPend), .syncMode(syncMode),
    .busIdle(busIdle), .wdogReq(wdogReq), .strobe(strobe),
    .opRst(opRst), .setRst(setRst), .skipOscWait(skipOscWait)
  );
endmodule

// File: rtl/swrst_chk.sv
module swrst_chk #(
  parameter int PULSE_LEN = 4
) (
  input logic clk,
  input logic rstN,
  input logic busIdle,
  input logic wdogReq,
  input logic opRst,
  input logic setRst
);
  localparam int RUN_W = $clog2(PULSE_LEN + 2);
  logic [RUN_W-1:0] runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      runLen <= '0;
    else if (opRst) runLen <= runLen + RUN_W'(1);
    else            runLen <= '0;
  end

  AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(opRst && setRst)); // R11
  AST_OP_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(opRst) |-> $past(busIdle)); // R4
  AST_OP_NOT_LONG: assert property (@(posedge clk) disable iff (!rstN)
    opRst |-> (runLen < RUN_W'(PULSE_LEN))); // R4
  AST_OP_FULL_LEN: assert property (@(posedge clk) disable iff (!rstN)
    (!opRst && runLen != '0) |-> (runLen == RUN_W'(PULSE_LEN))); // R4
  AST_SET_FROM_WDOG: assert property (@(posedge clk) disable iff (!rstN)
    $rose(setRst) |-> $past(wdogReq)); // R6
endmodule

bind swrst_ctrl swrst_chk #(.PULSE_LEN(PULSE_LEN)) chk_i (
  .clk(clk), .rstN(rstN), .busIdle(busIdle), .wdogReq(wdogReq),
  .opRst(opRst), .setRst(setRst)
);

// File: tb/swrst_ctrl_tb_top.sv
module swrst_ctrl_tb_top;
  localparam int PL = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        rdEn = 1'b0;
  logic [1:0]  rdAddr = '0;
  logic [15:0] rdData;
  logic        busIdle = 1'b0;
  logic        wdogReq = 1'b0;
  logic        opRst, setRst, skipOscWait;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  swrst_ctrl #(.PULSE_LEN(PL)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .busIdle(busIdle),
    .wdogReq(wdogReq), .opRst(opRst), .setRst(setRst), .skipOscWait(skipOscWait)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output int v);
    @(negedge clk);
    rdEn = 1'b1; rdAddr = a;
    #1 v = int'(rdData);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  initial begin
    int v;
    int opN, setN, skipBad, firstOp;
    int expOp, expSet;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 opRst", int'(opRst), 0);
    check("R1 setRst", int'(setRst), 0);
    check("R1 skipOscWait", int'(skipOscWait), 0);
    regRead(2'd0, v); check("R1 standby", v, 32'h0010);
    regRead(2'd1, v); check("R1 timebase", v, 0);
    regRead(2'd2, v); check("R1 source", v, 0);

    // R2 writing 1 to bit 4 makes no request
    regWrite(2'd1, 16'h0080);
    busIdle = 1'b1;
    regWrite(2'd0, 16'h0010);
    opN = 0;
    for (int i = 0; i < 10; i++) begin @(negedge clk); opN += int'(opRst); end
    check("R2 no request from bit4=1", opN, 0);
    regRead(2'd0, v); check("R2 standby bit4 stays 1", v & 32'h10, 32'h10);
    busIdle = 1'b0;

    // R3 sweep over bus idle and sync mode
    for (int c = 0; c < 4; c++) begin
      busIdle = 1'b0;
      regWrite(2'd1, 16'h0000);
      regWrite(2'd0, 16'h0000);
      regRead(2'd0, v); check("R2 pending reads bit4=0", v & 32'h10, 0);
      opN = 0;
      @(negedge clk);
      busIdle = c[0];
      wrEn = 1'b1; wrAddr = 2'd1; wrData = c[1] ? 16'h0080 : 16'h0000;
      @(negedge clk); wrEn = 1'b0; opN += int'(opRst);
      for (int i = 0; i < 20; i++) begin @(negedge clk); opN += int'(opRst); end
      if (c == 3) begin
        check("R4 pulse length when ready", opN, PL);
        regRead(2'd0, v); check("R4 pending cleared", v & 32'h10, 32'h10);
        regRead(2'd2, v); check("R5 sw cause bit11", v, 32'h0800);
      end else begin
        check("R3 no reset while not ready", opN, 0);
        regRead(2'd0, v); check("R3 still pending", v & 32'h10, 0);
      end
    end

    // R8 / R6 / R7 watchdog offset sweep against the release edge
    for (int off = -1; off <= 6; off++) begin
      busIdle = 1'b0;
      regWrite(2'd0, 16'h0000);
      opN = 0; setN = 0; skipBad = 0; firstOp = -99;
      for (int j = -2; j <= 14; j++) begin
        @(negedge clk);
        opN += int'(opRst);
        setN += int'(setRst);
        if (skipOscWait != setRst) skipBad++;
        if (opRst && firstOp == -99) firstOp = j;
        busIdle = (j >= 0);
        wdogReq = (j == off);
      end
      wdogReq = 1'b0;
      expOp  = (off >= 0) ? PL : 0;
      expSet = (off == -1 || off >= 5) ? PL : 0;
      check($sformatf("R8 op cycles off=%0d", off), opN, expOp);
      check($sformatf("R8 set cycles off=%0d", off), setN, expSet);
      check($sformatf("R6 skip follows set off=%0d", off), skipBad, 0);
      if (off >= 0) check($sformatf("R4 op rises one edge after release off=%0d", off), firstOp, 1);
      regRead(2'd2, v);
      check($sformatf("R5 R6 cause flags off=%0d", off), v,
            ((expOp != 0) ? 32'h0800 : 0) | ((expSet != 0) ? 32'h2000 : 0));
      if (off == -1) begin
        regRead(2'd0, v); check("R7 settings reset drops request", v & 32'h10, 32'h10);
      end
    end
    busIdle = 1'b0;

    // R9 read-clear colliding with a new watchdog flag
    regRead(2'd2, v); check("R9 flags cleared by read", v, 0);
    @(negedge clk);
    wdogReq = 1'b1; rdEn = 1'b1; rdAddr = 2'd2;
    #1 v = int'(rdData);
    check("R9 read before new flag", v, 0);
    @(negedge clk);
    wdogReq = 1'b0; rdEn = 1'b0;
    regRead(2'd2, v); check("R9 flag set at read edge survives", v, 32'h2000);
    regRead(2'd2, v); check("R9 second read sees cleared", v, 0);

    // R10 source register ignores writes
    repeat (8) @(negedge clk);
    regWrite(2'd2, 16'hFFFF);
    regRead(2'd2, v); check("R10 source write ignored", v, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule